// File: doc/BRIEF.md
# TDM Bit and Frame Clock Generator

This block runs an audio serial port as clock master. It divides the master clock into a bit clock. It also produces a frame sync whose shape depends on the selected serial format. Software sets the format, the slot count, the slot width, the master-to-bit-clock ratio and the two output polarities on static configuration inputs while `en` is low. It then raises `en`, and both clocks start together at the first bit of slot 0.

The frame holds `slots × width` bit clocks. Stereo-style formats (I2S, left-justified, right-justified) drive the frame sync high for the first half of the frame. DSP-style formats drive a single bit-clock-wide pulse. A combinational check flags any setup the generator cannot honour: a bad width, too many slots for a stereo format, an unknown format code, or a divide ratio that is not even. While the flag is set, the outputs stay idle.

Top module: `tdm_clkgen`

## Requirements
- R1: While reset is asserted, and after it until the generator is enabled, `bclk` equals `cfg_bclk_inv` and `fsync` equals `cfg_fs_inv`.
- R2: `cfg_err` is high whenever `cfg_width` is not one of 0, 8, 16, 24, 32. A width of 0 is legal and means 32 bits.
- R3: `cfg_err` is high when `cfg_fmt` is 0 (I2S), 1 (left-justified) or 2 (right-justified) with more than 2 slots. It is also high when the slot count is 0 or above MAX_SLOTS, and when `cfg_fmt` is 5, 6 or 7. Codes 3 (DSP-A) and 4 (DSP-B) accept 1 to MAX_SLOTS slots.
- R4: The effective ratio is `cfg_div`, or 4 when `cfg_div` is 0. `cfg_err` is high when the effective ratio is odd, which includes 1.
- R5: In the mclk cycle after the edge that samples `en` high with no error, the bit clock period starts. Each period lasts exactly the effective ratio in mclk cycles: the first half low and the second half high, before polarity.
- R6: A frame lasts `slots × w` bit clock periods, where w is the width with 0 read as 32.
- R7: For formats 0, 1 and 2, the frame sync before polarity is high during bit clocks 0 to L/2−1 of each frame and low for the rest.
- R8: For formats 3 and 4, the frame sync before polarity is high during bit clock 0 only.
- R9: `bclk` is the bit clock XOR `cfg_bclk_inv`, and `fsync` is the frame sync XOR `cfg_fs_inv`. The two inversions are independent.
- R10: One mclk edge after `en` is sampled low, or while `cfg_err` is high, both outputs return to their inactive levels (R1). The next enable restarts from bit 0 of a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; configuration changes only while low |
| cfg_fmt | input | 3 | Format code: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP-A, 4 DSP-B |
| cfg_slots | input | $clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_width | input | 6 | Slot width in bits (0 means 32) |
| cfg_div | input | DIV_W | Master clocks per bit clock (0 means 4) |
| cfg_bclk_inv | input | 1 | Bit clock polarity inversion |
| cfg_fs_inv | input | 1 | Frame sync polarity inversion |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
A divider counter that drifts changes the bit clock period or its low/high split within one period, so it shows in the first `ratio` cycles after enable. A frame counter that wraps at the wrong count moves the next frame sync edge, which shows at the end of the first frame. A wrong half-frame or pulse decode changes the frame sync width inside that same first frame. Restart and idle faults show one mclk edge after `en` falls, or on the first sample after re-enable, where bit 0 must open with the sync active and the bit clock low.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;

   typedef enum logic [2:0] {
      FMT_I2S   = 3'd0,
      FMT_LEFT  = 3'd1,
      FMT_RIGHT = 3'd2,
      FMT_DSP_A = 3'd3,
      FMT_DSP_B = 3'd4
   } tdm_fmt_e;

   localparam int unsigned DEFAULT_RATIO = 4;
   localparam int unsigned MAX_SLOT_BITS = 32;
   localparam int unsigned STEREO_SLOTS  = 2;

   function automatic logic width_legal(input logic [5:0] w);
      return (w == 6'd0) || (w == 6'd8) || (w == 6'd16) || (w == 6'd24) || (w == 6'd32);
   endfunction

   function automatic logic [5:0] width_eff(input logic [5:0] w);
      return (w == 6'd0) ? 6'(MAX_SLOT_BITS) : w;
   endfunction

   function automatic logic fmt_half_frame(input logic [2:0] f);
      return (f == FMT_I2S) || (f == FMT_LEFT) || (f == FMT_RIGHT);
   endfunction

   function automatic logic fmt_known(input logic [2:0] f);
      return fmt_half_frame(f) || (f == FMT_DSP_A) || (f == FMT_DSP_B);
   endfunction

endpackage

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
   import tdm_clkgen_pkg::*;
#(
   parameter int MAX_SLOTS = 16,
   parameter int DIV_W     = 8,
   parameter int SLOT_W    = $clog2(MAX_SLOTS + 1),
   parameter int FRAME_W   = $clog2(MAX_SLOTS * 32 + 1)
) (
   input  logic [2:0]         cfg_fmt,
   input  logic [SLOT_W-1:0]  cfg_slots,
   input  logic [5:0]         cfg_width,
   input  logic [DIV_W-1:0]   cfg_div,
   output logic               cfg_err,
   output logic [DIV_W-1:0]   ratio,
   output logic [DIV_W-1:0]   half_ratio,
   output logic [FRAME_W-1:0] frame_len,
   output logic [FRAME_W-1:0] half_frame,
   output logic               pulse_mode
);

   logic e_fmt, e_width, e_ratio, e_stereo, e_zero, e_over;

   // slot counts above MAX_SLOTS only need a compare when the port can encode them
   generate
      if ((1 << SLOT_W) - 1 > MAX_SLOTS) begin : g_over_chk
         assign e_over = cfg_slots > SLOT_W'(MAX_SLOTS);
      end else begin : g_over_none
         assign e_over = 1'b0;
      end
   endgenerate

   always_comb begin
      ratio      = (cfg_div == '0) ? DIV_W'(DEFAULT_RATIO) : cfg_div;
      half_ratio = ratio >> 1;
      frame_len  = FRAME_W'(cfg_slots) * FRAME_W'(width_eff(cfg_width));
      half_frame = frame_len >> 1;
      pulse_mode = !fmt_half_frame(cfg_fmt);
      e_fmt      = !fmt_known(cfg_fmt);
      e_width    = !width_legal(cfg_width);
      e_ratio    = ratio[0];
      e_zero     = (cfg_slots == '0);
      e_stereo   = fmt_half_frame(cfg_fmt) && (cfg_slots > SLOT_W'(STEREO_SLOTS));
      cfg_err    = e_fmt | e_width | e_ratio | e_zero | e_over | e_stereo;
   end

endmodule

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic [DIV_W-1:0] ratio,
   input  logic [DIV_W-1:0] half_ratio,
   output logic             bit_adv,
   output logic             bclk_nxt
);

   logic [DIV_W-1:0] cnt_q, cnt_d;
   logic             wrap;

   assign wrap = (cnt_q == ratio - DIV_W'(1));

   always_comb begin
      if (!run || start) begin
         cnt_d = '0;
      end else if (wrap) begin
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + DIV_W'(1);
      end
   end

   assign bit_adv  = run && !start && wrap;
   assign bclk_nxt = run && (cnt_d >= half_ratio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/tdm_frame_cnt.sv
module tdm_frame_cnt #(
   parameter int FRAME_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               start,
   input  logic               bit_adv,
   input  logic [FRAME_W-1:0] frame_len,
   input  logic [FRAME_W-1:0] half_frame,
   input  logic               pulse_mode,
   output logic               fs_nxt
);

   logic [FRAME_W-1:0] bit_q, bit_d;

   always_comb begin
      if (!run || start) begin
         bit_d = '0;
      end else if (bit_adv) begin
         bit_d = (bit_q == frame_len - FRAME_W'(1)) ? '0 : bit_q + FRAME_W'(1);
      end else begin
         bit_d = bit_q;
      end
   end

   always_comb begin
      if (!run) begin
         fs_nxt = 1'b0;
      end else if (pulse_mode) begin
         fs_nxt = (bit_d == '0);
      end else begin
         fs_nxt = (bit_d < half_frame);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
      end else begin
         bit_q <= bit_d;
      end
   end

endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
   import tdm_clkgen_pkg::*;
#(
   parameter int MAX_SLOTS = 16,
   parameter int DIV_W     = 8,
   localparam int SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [2:0]        cfg_fmt,
   input  logic [SLOT_W-1:0] cfg_slots,
   input  logic [5:0]        cfg_width,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_bclk_inv,
   input  logic              cfg_fs_inv,
   output logic              bclk,
   output logic              fsync,
   output logic              cfg_err
);

   localparam int FRAME_W = $clog2(MAX_SLOTS * MAX_SLOT_BITS + 1);
   localparam int N_PINS  = 2;

   generate
      if (MAX_SLOTS < STEREO_SLOTS) begin : g_bad_slots
         $error("tdm_clkgen: MAX_SLOTS must be at least 2");
      end
      if (DIV_W < 3) begin : g_bad_div
         $error("tdm_clkgen: DIV_W must hold the default ratio of 4");
      end
   endgenerate

   logic [DIV_W-1:0]   ratio, half_ratio;
   logic [FRAME_W-1:0] frame_len, half_frame;
   logic               pulse_mode;
   logic               run_d, run_q, start;
   logic               bit_adv, bclk_nxt, fs_nxt;
   logic [N_PINS-1:0]  raw_nxt, inv, pins;

   tdm_cfg_check #(
      .MAX_SLOTS (MAX_SLOTS),
      .DIV_W     (DIV_W),
      .SLOT_W    (SLOT_W),
      .FRAME_W   (FRAME_W)
   ) u_cfg (
      .cfg_fmt    (cfg_fmt),
      .cfg_slots  (cfg_slots),
      .cfg_width  (cfg_width),
      .cfg_div    (cfg_div),
      .cfg_err    (cfg_err),
      .ratio      (ratio),
      .half_ratio (half_ratio),
      .frame_len  (frame_len),
      .half_frame (half_frame),
      .pulse_mode (pulse_mode)
   );

   assign run_d = en && !cfg_err;
   assign start = run_d && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else begin
         run_q <= run_d;
      end
   end

   tdm_bclk_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_d),
      .start      (start),
      .ratio      (ratio),
      .half_ratio (half_ratio),
      .bit_adv    (bit_adv),
      .bclk_nxt   (bclk_nxt)
   );

   tdm_frame_cnt #(
      .FRAME_W (FRAME_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_d),
      .start      (start),
      .bit_adv    (bit_adv),
      .frame_len  (frame_len),
      .half_frame (half_frame),
      .pulse_mode (pulse_mode),
      .fs_nxt     (fs_nxt)
   );

   assign raw_nxt = {fs_nxt, bclk_nxt};
   assign inv     = {cfg_fs_inv, cfg_bclk_inv};

   // one retiming flop per pad, polarity applied after the flop
   generate
      for (genvar i = 0; i < N_PINS; i++) begin : g_pin
         logic raw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               raw_q <= 1'b0;
            end else begin
               raw_q <= raw_nxt[i];
            end
         end
         assign pins[i] = raw_q ^ inv[i];
      end
   endgenerate

   assign bclk  = pins[0];
   assign fsync = pins[1];

endmodule

// File: rtl/tdm_clkgen_chk.sv
module tdm_clkgen_chk #(
   parameter int MAX_SLOTS = 16,
   parameter int DIV_W     = 8,
   localparam int SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [2:0]        cfg_fmt,
   input logic [SLOT_W-1:0] cfg_slots,
   input logic [5:0]        cfg_width,
   input logic [DIV_W-1:0]  cfg_div,
   input logic              cfg_bclk_inv,
   input logic              cfg_fs_inv,
   input logic              bclk,
   input logic              fsync,
   input logic              cfg_err
);

   logic        live;
   int unsigned hi_run, fs_run, eff;

   assign eff = (cfg_div == '0) ? 32'd4 : 32'(cfg_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= 1'b0;
         hi_run <= 0;
         fs_run <= 0;
      end else begin
         live   <= 1'b1;
         hi_run <= (bclk ^ cfg_bclk_inv) ? hi_run + 1 : 0;
         fs_run <= (fsync ^ cfg_fs_inv) ? fs_run + 1 : 0;
      end
   end

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      live && $past(!en || cfg_err) |-> (bclk == cfg_bclk_inv) && (fsync == cfg_fs_inv));

   assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_width inside {6'd0, 6'd8, 6'd16, 6'd24, 6'd32}) |-> cfg_err);

   assert_stereo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fmt <= 3'd2) && (cfg_slots > SLOT_W'(2)) |-> cfg_err);

   assert_odd_ratio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_div[0] |-> cfg_err);

   assert_bclk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en && !cfg_err |-> hi_run <= (eff >> 1));

   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !cfg_err && (cfg_fmt >= 3'd3) |-> fs_run <= eff);

endmodule

bind tdm_clkgen tdm_clkgen_chk #(.MAX_SLOTS(MAX_SLOTS), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/tdm_clkgen_bench.sv
module tdm_clkgen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] fmt = 3'd0;
   logic [4:0] slots = 5'd2;
   logic [5:0] wid = 6'd16;
   logic [7:0] div = 8'd4;
   logic       bi = 1'b0;
   logic       fi = 1'b0;
   logic       bclk, fsync, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tdm_clkgen u_tdm_clkgen (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_fmt(fmt), .cfg_slots(slots),
      .cfg_width(wid), .cfg_div(div), .cfg_bclk_inv(bi), .cfg_fs_inv(fi),
      .bclk(bclk), .fsync(fsync), .cfg_err(cfg_err)
   );

   function automatic int eff_d();
      return (div == 0) ? 4 : int'(div);
   endfunction

   function automatic int flen();
      return int'(slots) * ((wid == 0) ? 32 : int'(wid));
   endfunction

   function automatic bit exp_err();
      bit bad;
      bad = (fmt > 3'd4) || (slots == 0) || (slots > 5'd16);
      bad = bad || !(wid inside {6'd0, 6'd8, 6'd16, 6'd24, 6'd32});
      bad = bad || ((fmt <= 3'd2) && (slots > 5'd2));
      bad = bad || (eff_d() % 2 == 1);
      return bad;
   endfunction

   function automatic bit exp_bclk(input int t);
      return ((t % eff_d()) >= eff_d() / 2) ^ bi;
   endfunction

   function automatic bit exp_fs(input int t);
      int b;
      b = (t / eff_d()) % flen();
      if (fmt <= 3'd2) return (b < flen() / 2) ^ fi;
      return (b == 0) ^ fi;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic set_cfg(input logic [2:0] f, input logic [4:0] s, input logic [5:0] w,
                          input logic [7:0] d, input logic b, input logic fs, input string req);
      @(negedge clk);
      fmt = f; slots = s; wid = w; div = d; bi = b; fi = fs;
      #1;
      check(cfg_err == exp_err(), req, "cfg_err", int'(cfg_err), int'(exp_err()));
   endtask

   // enable, compare n samples against the formula model, then disable and check idle
   task automatic run_stream(input string req, input int n);
      int bad_b, bad_f, fb_a, fb_e, ff_a, ff_e;
      bad_b = 0; bad_f = 0; fb_a = 0; fb_e = 0; ff_a = 0; ff_e = 0;
      @(negedge clk);
      en = 1'b1;
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         if (bclk != exp_bclk(t)) begin
            if (bad_b == 0) begin fb_a = t * 2 + int'(bclk); fb_e = t * 2 + int'(exp_bclk(t)); end
            bad_b++;
         end
         if (fsync != exp_fs(t)) begin
            if (bad_f == 0) begin ff_a = t * 2 + int'(fsync); ff_e = t * 2 + int'(exp_fs(t)); end
            bad_f++;
         end
      end
      check(bad_b == 0, "R5", {req, " bclk (2*cycle+level)"}, fb_a, fb_e);
      check(bad_f == 0, (fmt <= 3'd2) ? "R7" : "R8", {req, " fsync R6 (2*cycle+level)"}, ff_a, ff_e);
      en = 1'b0;
      @(negedge clk);
      check(bclk == bi && fsync == fi, "R10", {req, " idle after disable"},
            int'({bclk, fsync}), int'({bi, fi}));
      @(negedge clk);
   endtask

   function automatic int min_n(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
         finish_run();
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd7321);
      bi = 1'b0; fi = 1'b1;
      repeat (3) @(negedge clk);
      check(bclk == 1'b0 && fsync == 1'b1, "R1", "outputs in reset", int'({bclk, fsync}), 1);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(bclk == bi && fsync == fi, "R1", "idle after reset R9", int'({bclk, fsync}), 1);

      set_cfg(3'd0, 5'd2, 6'd12, 8'd4, 1'b0, 1'b0, "R2 width 12");
      set_cfg(3'd3, 5'd4, 6'd20, 8'd4, 1'b0, 1'b0, "R2 width 20");
      set_cfg(3'd0, 5'd3, 6'd16, 8'd4, 1'b0, 1'b0, "R3 i2s three slots");
      set_cfg(3'd2, 5'd3, 6'd8, 8'd4, 1'b0, 1'b0, "R3 rj three slots");
      set_cfg(3'd6, 5'd2, 6'd16, 8'd4, 1'b0, 1'b0, "R3 format code 6");
      set_cfg(3'd4, 5'd0, 6'd16, 8'd4, 1'b0, 1'b0, "R3 zero slots");
      set_cfg(3'd4, 5'd17, 6'd8, 8'd4, 1'b0, 1'b0, "R3 seventeen slots");
      set_cfg(3'd4, 5'd16, 6'd8, 8'd4, 1'b0, 1'b0, "R3 sixteen slots dsp");
      set_cfg(3'd3, 5'd4, 6'd16, 8'd3, 1'b0, 1'b0, "R4 ratio 3");
      set_cfg(3'd3, 5'd4, 6'd16, 8'd1, 1'b0, 1'b0, "R4 ratio 1");

      // error while enabled: outputs stay idle
      set_cfg(3'd1, 5'd2, 6'd16, 8'd5, 1'b1, 1'b0, "R4 ratio 5");
      @(negedge clk); en = 1'b1;
      begin
         int busy;
         busy = 0;
         for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (bclk != bi || fsync != fi) busy++;
         end
         check(busy == 0, "R10", "outputs idle while cfg_err", busy, 0);
      end
      en = 1'b0;
      @(negedge clk);

      set_cfg(3'd3, 5'd2, 6'd8, 8'd0, 1'b0, 1'b0, "R4 ratio 0 legal");
      run_stream("R4 default ratio 4", 2 * flen() * eff_d());
      set_cfg(3'd4, 5'd1, 6'd8, 8'd2, 1'b0, 1'b0, "R8 dsp-b one slot");
      run_stream("R8 dsp-b 8 bit frame", 3 * flen() * eff_d());
      set_cfg(3'd0, 5'd2, 6'd0, 8'd2, 1'b0, 1'b0, "R6 width 0 legal");
      run_stream("R6 width 0 means 32", 2 * flen() * eff_d());
      set_cfg(3'd3, 5'd3, 6'd8, 8'd6, 1'b1, 1'b1, "R9 both inverted");
      run_stream("R9 dsp-a inverted", 2 * flen() * eff_d());
      set_cfg(3'd1, 5'd1, 6'd24, 8'd2, 1'b0, 1'b1, "R9 fs only inverted");
      run_stream("R9 lj mono", 2 * flen() * eff_d());
      // restart: short run then a full one from bit 0
      run_stream("R10 partial run", 7);
      run_stream("R10 restart from bit 0", 2 * flen() * eff_d());

      for (int k = 0; k < 24; k++) begin
         logic [2:0] f;
         logic [4:0] s;
         logic [5:0] w;
         logic [7:0] d;
         f = 3'($urandom % 5);
         s = (f <= 3'd2) ? 5'(1 + $urandom % 2) : 5'(1 + $urandom % 8);
         w = 6'(8 * ($urandom % 5));
         d = 8'(2 * ($urandom % 6));
         set_cfg(f, s, w, d, 1'($urandom % 2), 1'($urandom % 2), "R3 random legal");
         run_stream((f <= 3'd2) ? "R7 random" : "R8 random", min_n(2 * flen() * eff_d(), 3000));
      end

      done = 1;
      finish_run();
   end

endmodule